// File: doc/BRIEF.md
# Serial Memory Slave Bus Link

This block is the bus side of a two-wire serial memory slave. It samples the clock and data lines on the system clock through two-flop synchronizers and suppresses short spikes. From the filtered lines it detects START, repeated START and STOP conditions. It shifts bytes in and out with the most significant bit first, and it drives the acknowledge bit in the ninth clock of each byte.

The first byte after any START selects the device. The upper nibble must be 1010 and the next three bits must equal the strap inputs, while bit 0 gives the direction. A transaction controller outside the block sees one-cycle pulses for START, STOP, a matched select byte (with the direction), a received data byte, and the master's acknowledge on reads. The controller supplies each byte to transmit on `tx_data_i`, and a pulse marks the cycle in which that byte is latched. The block never drives the data line high. Its only output to the line is an enable that pulls it low.

Top module: `i2c_mem_link`

## Requirements
- R1: After reset `sda_oe_o` is low, all event pulses are low, and the link waits in standby for a START.
- R2: Data falling while the clock is high gives one `start_o` pulse, and data rising while the clock is high gives one `stop_o` pulse. The two never pulse together, and STOP leaves `sda_oe_o` low.
- R3: A low or high pulse on either line shorter than `FILT_LEN` system clocks (default 10, about 100 ns at 100 MHz) produces no event and no change on `sda_oe_o`.
- R4: A select byte with bits 7..4 = 1010 and bits 3..1 = `strap_i` (bit 3 compared with `strap_i[2]`) is acknowledged. The data line is held low through the high phase of the ninth clock, `addr_hit_o` pulses, and `rw_o` takes bit 0 (1 = read).
- R5: A select byte that does not match is not acknowledged. The link then ignores the bus, with no further events except START and STOP, until the next START.
- R6: While `busy_i` is high, the device's own select byte is not acknowledged and `addr_hit_o` does not pulse.
- R7: In a write, each data byte received after the select byte gives an `rx_valid_o` pulse with the byte on `rx_data_o`, MSB first, and the byte is acknowledged.
- R8: After a read select byte is acknowledged, `tx_data_i` is latched at the clock fall that ends the ninth clock, and `tx_req_o` pulses. Its bits are driven MSB first, each changing after a clock fall, and the line is released for the ninth clock.
- R9: In a read, the master's ninth-clock bit gives a `mack_valid_o` pulse with `mack_nack_o` equal to that bit. An acknowledge (0) loads the next byte. A no-acknowledge (1) releases the data line and returns the link to standby, so later clocks see no driving.
- R10: A repeated START at any bit position abandons the current byte and restarts select-byte reception.
- R11: `sda_oe_o` changes only after a falling clock edge, START or STOP, and never during a clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (as seen on the wire) |
| strap_i | input | 3 | Hardware address straps, bits 3..1 of the select byte |
| busy_i | input | 1 | Internal write in progress; suppresses select acknowledge |
| tx_data_i | input | 8 | Next byte to send on reads |
| sda_oe_o | output | 1 | Pull the data line low when high |
| start_o | output | 1 | Pulse on START or repeated START |
| stop_o | output | 1 | Pulse on STOP |
| addr_hit_o | output | 1 | Pulse when the select byte matches and is acknowledged |
| rw_o | output | 1 | Direction of the last matched select byte, 1 = read |
| rx_valid_o | output | 1 | Pulse when a data byte has been received |
| rx_data_o | output | 8 | Last received data byte |
| tx_req_o | output | 1 | Pulse when `tx_data_i` is latched |
| mack_valid_o | output | 1 | Pulse when the master's ninth-clock bit on a read is sampled |
| mack_nack_o | output | 1 | Master's ninth-clock bit, 1 = no-acknowledge |

## Verification
A line edge reaches the filtered domain 2 synchronizer cycles plus `FILT_LEN` cycles after it reaches the pin. Each event pulse appears one register stage later, about 13 cycles at the defaults. `sda_oe_o` changes in that same cycle after the clock fall it follows. The bench holds each quarter of a bus clock for 50 system cycles. It samples the line and the acknowledge bit in the middle of the clock high phase, well after the last output change it could see. The scoreboard monitor matches event pulses against the queue as they occur, on the falling system clock edge, so it depends on event order rather than on an exact cycle count.

// File: rtl/i2c_link_pkg.sv
package i2c_link_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CNT_W    = $clog2(BYTE_W);
  localparam logic [3:0]  DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK_DRV,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT
  } link_state_e;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int unsigned FILT_LEN = 10,
  parameter bit          RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != filt_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          filt_q <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_prev_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_det_o,
  output logic stop_det_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_prev_o  = scl_q;
  assign scl_rise_o  = scl_f_i & ~scl_q;
  assign scl_fall_o  = ~scl_f_i & scl_q;
  assign start_det_o = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_det_o  = scl_f_i & scl_q & ~sda_q & sda_f_i;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_link_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_f_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              addr_hit_o,
  output logic              rw_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              tx_req_o,
  output logic              mack_valid_o,
  output logic              mack_nack_o
);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

  link_state_e       state_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-2:0] shreg_q;
  logic              is_sel_q;
  logic              sel_ok;

  // shreg holds bits 7..1 when the eighth bit arrives
  assign sel_ok = (shreg_q[6:3] == DEV_TYPE) && (shreg_q[2:0] == strap_i) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      bit_q        <= '0;
      shreg_q      <= '0;
      is_sel_q     <= 1'b0;
      sda_oe_o     <= 1'b0;
      start_o      <= 1'b0;
      stop_o       <= 1'b0;
      addr_hit_o   <= 1'b0;
      rw_o         <= 1'b0;
      rx_valid_o   <= 1'b0;
      rx_data_o    <= '0;
      tx_req_o     <= 1'b0;
      mack_valid_o <= 1'b0;
      mack_nack_o  <= 1'b0;
    end else begin
      start_o      <= 1'b0;
      stop_o       <= 1'b0;
      addr_hit_o   <= 1'b0;
      rx_valid_o   <= 1'b0;
      tx_req_o     <= 1'b0;
      mack_valid_o <= 1'b0;
      if (start_det_i) begin
        state_q  <= ST_RX;
        bit_q    <= '0;
        is_sel_q <= 1'b1;
        sda_oe_o <= 1'b0;
        start_o  <= 1'b1;
      end else if (stop_det_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
        stop_o   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_RX: if (scl_rise_i) begin
            shreg_q <= {shreg_q[BYTE_W-3:0], sda_f_i};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == BIT_LAST) begin
              if (is_sel_q) begin
                if (sel_ok) begin
                  addr_hit_o <= 1'b1;
                  rw_o       <= sda_f_i;
                  state_q    <= ST_ACK_WAIT;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                rx_valid_o <= 1'b1;
                rx_data_o  <= {shreg_q, sda_f_i};
                state_q    <= ST_ACK_WAIT;
              end
            end
          end
          ST_ACK_WAIT: if (scl_fall_i) begin
            sda_oe_o <= 1'b1;
            state_q  <= ST_ACK_DRV;
          end
          ST_ACK_DRV: if (scl_fall_i) begin
            bit_q    <= '0;
            is_sel_q <= 1'b0;
            if (is_sel_q && rw_o) begin
              shreg_q  <= tx_data_i[BYTE_W-2:0];
              sda_oe_o <= ~tx_data_i[BYTE_W-1];
              tx_req_o <= 1'b1;
              state_q  <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall_i) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == BIT_LAST) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_TX_ACK;
            end else begin
              sda_oe_o <= ~shreg_q[BYTE_W-2];
              shreg_q  <= shreg_q << 1;
            end
          end
          ST_TX_ACK: if (scl_rise_i) begin
            mack_valid_o <= 1'b1;
            mack_nack_o  <= sda_f_i;
            state_q      <= sda_f_i ? ST_IDLE : ST_TX_NEXT;
          end
          ST_TX_NEXT: if (scl_fall_i) begin
            bit_q    <= '0;
            shreg_q  <= tx_data_i[BYTE_W-2:0];
            sda_oe_o <= ~tx_data_i[BYTE_W-1];
            tx_req_o <= 1'b1;
            state_q  <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_link.sv
module i2c_mem_link
  import i2c_link_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned SPIKE_NS = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              addr_hit_o,
  output logic              rw_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              tx_req_o,
  output logic              mack_valid_o,
  output logic              mack_nack_o
);
  localparam int unsigned FILT_RAW = (CLK_MHZ * SPIKE_NS + 999) / 1000;
  localparam int unsigned FILT_LEN = (FILT_RAW < 1) ? 1 : FILT_RAW;

  logic [1:0] pin_raw, pin_filt;
  logic       scl_f, sda_f, scl_prev, scl_rise, scl_fall, start_det, stop_det;

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_pin_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (pin_raw[g]),
      .filt_o (pin_filt[g])
    );
  end

  assign scl_f = pin_filt[0];
  assign sda_f = pin_filt[1];

  i2c_bus_events u_events (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_f_i     (scl_f),
    .sda_f_i     (sda_f),
    .scl_prev_o  (scl_prev),
    .scl_rise_o  (scl_rise),
    .scl_fall_o  (scl_fall),
    .start_det_o (start_det),
    .stop_det_o  (stop_det)
  );

  i2c_byte_engine u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_f_i      (sda_f),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_det_i  (start_det),
    .stop_det_i   (stop_det),
    .strap_i      (strap_i),
    .busy_i       (busy_i),
    .tx_data_i    (tx_data_i),
    .sda_oe_o     (sda_oe_o),
    .start_o      (start_o),
    .stop_o       (stop_o),
    .addr_hit_o   (addr_hit_o),
    .rw_o         (rw_o),
    .rx_valid_o   (rx_valid_o),
    .rx_data_o    (rx_data_o),
    .tx_req_o     (tx_req_o),
    .mack_valid_o (mack_valid_o),
    .mack_nack_o  (mack_nack_o)
  );
endmodule

// File: rtl/i2c_mem_link_chk.sv
module i2c_mem_link_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic scl_prev,
  input logic start_det,
  input logic stop_det,
  input logic busy_i,
  input logic sda_oe_o,
  input logic start_o,
  input logic stop_o,
  input logic addr_hit_o,
  input logic rx_valid_o,
  input logic mack_valid_o,
  input logic mack_nack_o
);
  assert_start_stop_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o}));

  assert_stop_releases_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !sda_oe_o);

  assert_busy_no_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hit_o |-> !$past(busy_i));

  assert_rx_line_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !sda_oe_o);

  assert_nack_releases_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mack_valid_o && mack_nack_o) |-> !sda_oe_o);

  assert_oe_stable_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f && scl_prev && !start_det && !stop_det) |=> $stable(sda_oe_o));
endmodule

bind i2c_mem_link i2c_mem_link_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_f        (scl_f),
  .scl_prev     (scl_prev),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .busy_i       (busy_i),
  .sda_oe_o     (sda_oe_o),
  .start_o      (start_o),
  .stop_o       (stop_o),
  .addr_hit_o   (addr_hit_o),
  .rx_valid_o   (rx_valid_o),
  .mack_valid_o (mack_valid_o),
  .mack_nack_o  (mack_nack_o)
);

// File: tb/i2c_mem_link_bench.sv
`timescale 1ns/1ps
module i2c_mem_link_bench;
  localparam int Q = 50;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int EV_START = 0, EV_STOP = 1, EV_HIT = 2, EV_RX = 3, EV_MACK = 4, EV_TXREQ = 5;

  typedef struct { int kind; int data; } ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, start_p, stop_p, hit_p, rw, rxv, txreq, mackv, mnack;
  logic [7:0] rxd;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  ev_t exp_q[$];

  always #5 clk = ~clk;

  i2c_mem_link u_i2c_mem_link (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .busy_i(busy), .tx_data_i(tx_data),
    .sda_oe_o(sda_oe), .start_o(start_p), .stop_o(stop_p),
    .addr_hit_o(hit_p), .rw_o(rw), .rx_valid_o(rxv), .rx_data_o(rxd),
    .tx_req_o(txreq), .mack_valid_o(mackv), .mack_nack_o(mnack)
  );

  function automatic string req_of(int k);
    case (k)
      EV_START, EV_STOP: return "R2";
      EV_HIT:            return "R4";
      EV_RX:             return "R7";
      EV_MACK:           return "R9";
      default:           return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int k, int d);
    ev_t e; e.kind = k; e.data = d; exp_q.push_back(e);
  endtask

  task automatic got(int k, int d);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R3/R5 unexpected event", k, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k && e.data == d, req_of(e.kind), k * 256 + d, e.kind * 256 + e.data);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (start_p) got(EV_START, 0);
    if (stop_p)  got(EV_STOP, 0);
    if (hit_p)   got(EV_HIT, int'(rw));
    if (rxv)     got(EV_RX, int'(rxd));
    if (mackv)   got(EV_MACK, int'(mnack));
    if (txreq)   got(EV_TXREQ, 0);
  end

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; hq(); sda_m = 1'b0; hq(); scl = 1'b0; hq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; hq(); scl = 1'b1; hq(); sda_m = 1'b0; hq(); scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl = 1'b1; hq(); sda_m = 1'b1; hq(); hq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hq(); scl = 1'b1; hq(); ack = sda_line; hq(); scl = 1'b0; hq();
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq(); scl = 1'b1; hq(); b = {b[6:0], sda_line}; hq(); scl = 1'b0;
    end
    hq(); sda_m = nack; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq(); sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    logic line_ok;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!sda_oe && !start_p && !stop_p && !hit_p && !rxv && !txreq && !mackv,
          "R1", int'(sda_oe), 0);

    // R3: spikes on both lines in idle, SDA low while SCL high would be a START
    sda_m = 1'b0; repeat (6) @(negedge clk); sda_m = 1'b1; repeat (30) @(negedge clk);
    scl = 1'b0; repeat (6) @(negedge clk); scl = 1'b1; repeat (30) @(negedge clk);
    check(exp_q.size() == 0 && !sda_oe, "R3", int'(sda_oe), 0);

    // R4, R7: write of two bytes
    push(EV_START, 0); push(EV_HIT, 0);
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, ack);
    check(ack == 1'b0, "R4 select ack", int'(ack), 0);
    push(EV_RX, 8'h3C);
    write_byte(8'h3C, ack);
    check(ack == 1'b0, "R7 data ack", int'(ack), 0);
    push(EV_RX, 8'hA5);
    write_byte(8'hA5, ack);
    check(ack == 1'b0, "R7 data ack", int'(ack), 0);
    push(EV_STOP, 0);
    bus_stop();

    // R5: wrong strap, then a data byte must be ignored
    push(EV_START, 0);
    bus_start();
    write_byte({4'b1010, 3'b001, 1'b0}, ack);
    check(ack == 1'b1, "R5 mismatch nack", int'(ack), 1);
    write_byte(8'h55, ack);
    check(ack == 1'b1, "R5 ignored data", int'(ack), 1);
    push(EV_STOP, 0);
    bus_stop();

    // R6: busy suppresses select ack
    busy = 1'b1;
    push(EV_START, 0);
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, ack);
    check(ack == 1'b1, "R6 busy nack", int'(ack), 1);
    push(EV_STOP, 0);
    bus_stop();
    busy = 1'b0;

    // R8, R9: read two bytes, ack then nack
    tx_data = 8'hC3;
    push(EV_START, 0); push(EV_HIT, 1); push(EV_TXREQ, 0);
    bus_start();
    write_byte({4'b1010, STRAP, 1'b1}, ack);
    check(ack == 1'b0, "R4 read select ack", int'(ack), 0);
    tx_data = 8'h5A;
    push(EV_MACK, 0); push(EV_TXREQ, 0);
    read_byte(1'b0, rb);
    check(rb == 8'hC3, "R8 first byte", int'(rb), 8'hC3);
    push(EV_MACK, 1);
    read_byte(1'b1, rb);
    check(rb == 8'h5A, "R8 second byte", int'(rb), 8'h5A);
    // R9: after nack the line stays released while clocks continue
    line_ok = 1'b1;
    for (int i = 0; i < 9; i++) begin
      hq(); scl = 1'b1; hq(); line_ok &= sda_line; hq(); scl = 1'b0; hq();
    end
    check(line_ok == 1'b1, "R9 released after nack", int'(line_ok), 1);
    push(EV_STOP, 0);
    bus_stop();

    // R10: repeated START in mid byte restarts select reception
    push(EV_START, 0);
    bus_start();
    send_bits(8'hF0, 4);
    push(EV_START, 0); push(EV_HIT, 0);
    bus_rstart();
    write_byte({4'b1010, STRAP, 1'b0}, ack);
    check(ack == 1'b0, "R10 select after restart", int'(ack), 0);
    push(EV_RX, 8'h81);
    write_byte(8'h81, ack);
    check(ack == 1'b0, "R10 data after restart", int'(ack), 0);

    // R10, R8: repeated START after a data byte switches to read
    tx_data = 8'h96;
    push(EV_START, 0); push(EV_HIT, 1); push(EV_TXREQ, 0);
    bus_rstart();
    write_byte({4'b1010, STRAP, 1'b1}, ack);
    check(ack == 1'b0, "R10 read select", int'(ack), 0);
    push(EV_MACK, 1);
    read_byte(1'b1, rb);
    check(rb == 8'h96, "R8 byte after restart", int'(rb), 8'h96);
    push(EV_STOP, 0);
    bus_stop();

    repeat (100) @(negedge clk);
    check(exp_q.size() == 0, "R2 all events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule